// File: doc/BRIEF.md
# Neutral-Point Current Selector and Charge Integrator

This block sits beside the modulator of a three-level neutral-point-clamped converter. Every clock it takes the level code chosen for each of the three phase legs and the three sampled, signed load currents. From the set of legs clamped to the middle level, it works out the current that the present switching vector draws from the capacitor midpoint. It then sums that current over one switching period. The per-period sum is proportional to the change of the midpoint voltage, because that change equals the charge divided by twice the capacitance of one bus capacitor. Scaling by capacitance is left to downstream logic.

Large vectors and zero vectors are marked with a flag and contribute nothing. Every other vector contributes the negated sum of the currents of its middle-level legs. Under three-wire balance this reduces to a single phase current or its negation. A period strobe captures the running sum into a snapshot register and restarts the sum. The running sum saturates rather than wrapping, and a saturation event sets a flag that stays set.

Top module: `npc_np_integrator`

## Requirements
- R1: While reset is asserted, and after it is released until the first input is registered, every output is zero.
- R2: Leg level codes are 2'b00 for negative, 2'b01 for middle, and 2'b10 for positive. Code 2'b11 is treated as a non-middle level. When no leg is at the middle level, or all three legs are, `np_idle` is 1 and `np_cur` is 0 one clock after the inputs.
- R3: When one or two legs are at the middle level, `np_cur` equals the negated sum of those legs' currents. It appears one clock after the inputs and `np_idle` is 0.
- R4: On a clock with `period_stb` high, `chg_snap` takes the running sum including that clock's sample, and `chg_vld` is 1 for exactly the following cycle.
- R5: After a strobe the running sum restarts from zero, so the next snapshot holds only the samples taken after the strobe clock.
- R6: `chg_snap` holds its value on clocks without a strobe.
- R7: The running sum saturates at the largest positive or most negative value of `ACC_W` bits instead of wrapping.
- R8: `chg_ovf` goes to 1 on the clock a saturation occurs, stays 1 until reset, and returns to 0 on reset.
- R9: Vectors flagged by R2 add nothing to the running sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_a | input | 2 | Level code of leg a |
| lvl_b | input | 2 | Level code of leg b |
| lvl_c | input | 2 | Level code of leg c |
| cur_a | input | CUR_W | Signed current of leg a |
| cur_b | input | CUR_W | Signed current of leg b |
| cur_c | input | CUR_W | Signed current of leg c |
| period_stb | input | 1 | Marks the last clock of a switching period |
| np_cur | output | CUR_W+2 | Signed midpoint current of the registered vector |
| np_idle | output | 1 | Registered vector has no midpoint effect |
| chg_snap | output | ACC_W | Signed charge summed over the last completed period |
| chg_vld | output | 1 | One-cycle pulse after a snapshot |
| chg_ovf | output | 1 | Sticky saturation flag |

## Verification
The current, the idle flag, the snapshot, its valid pulse and the overflow flag all become visible at the first rising edge after the inputs are applied, so each result is due exactly one cycle after its stimulus. The bench drives inputs at the falling edge. It advances its own requirement-based model at the next rising edge and compares all outputs one nanosecond later, before any further input changes. The saturation runs step the model cycle by cycle, so the clock on which the flag rises is checked exactly rather than within a window.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [1:0] LVL_NEG = 2'b00;
  localparam logic [1:0] LVL_MID = 2'b01;
  localparam logic [1:0] LVL_POS = 2'b10;
  localparam int         N_LEGS  = 3;
endpackage

// File: rtl/npc_vector_classify.sv
module npc_vector_classify
  import npc_pkg::*;
(
  input  logic [1:0]        lvl [N_LEGS],
  output logic [N_LEGS-1:0] mid,
  output logic              no_eff
);
  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    assign mid[g] = (lvl[g] == LVL_MID);
  end

  // Large and zero vectors: no leg clamped, or every leg clamped
  assign no_eff = (mid == '0) || (&mid);
endmodule

// File: rtl/npc_current_select.sv
module npc_current_select
  import npc_pkg::*;
#(
  parameter int CUR_W = 12,
  localparam int NP_W = CUR_W + 2
) (
  input  logic signed [CUR_W-1:0] cur [N_LEGS],
  input  logic [N_LEGS-1:0]       mid,
  input  logic                    no_eff,
  output logic signed [NP_W-1:0]  np
);
  always_comb begin
    np = '0;
    for (int k = 0; k < N_LEGS; k++) begin
      if (mid[k] && !no_eff) begin
        np = np - {{(NP_W-CUR_W){cur[k][CUR_W-1]}}, cur[k]};
      end
    end
  end
endmodule

// File: rtl/npc_charge_accum.sv
module npc_charge_accum #(
  parameter int NP_W  = 14,
  parameter int ACC_W = 20,
  localparam int SUM_W = ACC_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [NP_W-1:0]  np,
  input  logic                    stb,
  output logic signed [ACC_W-1:0] snap_q,
  output logic                    vld_q,
  output logic                    ovf_q
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, acc_d, snap_d, sat_val;
  logic signed [SUM_W-1:0] sum_w;
  logic                    sat_hit, vld_d, ovf_d;

  always_comb begin
    sum_w   = {acc_q[ACC_W-1], acc_q} + {{(SUM_W-NP_W){np[NP_W-1]}}, np};
    sat_hit = (sum_w[SUM_W-1] != sum_w[SUM_W-2]);
    if (!sat_hit)              sat_val = sum_w[ACC_W-1:0];
    else if (sum_w[SUM_W-1])   sat_val = ACC_MIN;
    else                       sat_val = ACC_MAX;
    acc_d  = stb ? '0 : sat_val;
    snap_d = sat_val;
    vld_d  = stb;
    ovf_d  = ovf_q | sat_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      snap_q <= '0;
      vld_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      vld_q <= vld_d;
      ovf_q <= ovf_d;
      if (stb) snap_q <= snap_d;
    end
  end

  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (acc_q == '0)); // R5
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(snap_q)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R8
endmodule

// File: rtl/npc_np_integrator.sv
module npc_np_integrator
  import npc_pkg::*;
#(
  parameter int CUR_W = 12,
  parameter int ACC_W = 20,
  localparam int NP_W = CUR_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              lvl_a,
  input  logic [1:0]              lvl_b,
  input  logic [1:0]              lvl_c,
  input  logic signed [CUR_W-1:0] cur_a,
  input  logic signed [CUR_W-1:0] cur_b,
  input  logic signed [CUR_W-1:0] cur_c,
  input  logic                    period_stb,
  output logic signed [NP_W-1:0]  np_cur,
  output logic                    np_idle,
  output logic signed [ACC_W-1:0] chg_snap,
  output logic                    chg_vld,
  output logic                    chg_ovf
);
  logic [1:0]              lvl_v [N_LEGS];
  logic signed [CUR_W-1:0] cur_v [N_LEGS];
  logic [N_LEGS-1:0]       mid;
  logic                    no_eff;
  logic signed [NP_W-1:0]  np_d, np_q;
  logic                    idle_q;

  assign lvl_v[0] = lvl_a;
  assign lvl_v[1] = lvl_b;
  assign lvl_v[2] = lvl_c;
  assign cur_v[0] = cur_a;
  assign cur_v[1] = cur_b;
  assign cur_v[2] = cur_c;

  npc_vector_classify u_cls (
    .lvl    (lvl_v),
    .mid    (mid),
    .no_eff (no_eff)
  );

  npc_current_select #(.CUR_W(CUR_W)) u_sel (
    .cur    (cur_v),
    .mid    (mid),
    .no_eff (no_eff),
    .np     (np_d)
  );

  npc_charge_accum #(.NP_W(NP_W), .ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .np     (np_d),
    .stb    (period_stb),
    .snap_q (chg_snap),
    .vld_q  (chg_vld),
    .ovf_q  (chg_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      np_q   <= '0;
      idle_q <= 1'b0;
    end else begin
      np_q   <= np_d;
      idle_q <= no_eff;
    end
  end

  assign np_cur  = np_q;
  assign np_idle = idle_q;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    np_idle |-> (np_cur == '0)); // R2
  AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    chg_vld |-> $past(period_stb)); // R4
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    period_stb |=> chg_vld); // R4
endmodule

// File: tb/npc_np_integrator_tb.sv
`timescale 1ns/1ps
module npc_np_integrator_tb;
  localparam int CUR_W = 12;
  localparam int ACC_W = 20;
  localparam int NP_W  = CUR_W + 2;
  localparam int A_MAX = (1 << (ACC_W-1)) - 1;
  localparam int A_MIN = -(1 << (ACC_W-1));
  localparam logic [1:0] N = 2'b00, O = 2'b01, P = 2'b10, X = 2'b11;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] lvl_a, lvl_b, lvl_c;
  logic signed [CUR_W-1:0] cur_a, cur_b, cur_c;
  logic period_stb;
  logic signed [NP_W-1:0] np_cur;
  logic np_idle;
  logic signed [ACC_W-1:0] chg_snap;
  logic chg_vld, chg_ovf;

  int n_chk = 0, n_bad = 0;
  int m_np, m_idle, m_acc, m_snap, m_vld, m_ovf;

  always #2.5 clk = ~clk;

  npc_np_integrator #(.CUR_W(CUR_W), .ACC_W(ACC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c),
    .cur_a(cur_a), .cur_b(cur_b), .cur_c(cur_c), .period_stb(period_stb),
    .np_cur(np_cur), .np_idle(np_idle), .chg_snap(chg_snap),
    .chg_vld(chg_vld), .chg_ovf(chg_ovf)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " np_cur"},   int'(np_cur),   m_np);
    check({tag, " np_idle"},  int'(np_idle),  m_idle);
    check({tag, " chg_snap"}, int'(chg_snap), m_snap);
    check({tag, " chg_vld"},  int'(chg_vld),  m_vld);
    check({tag, " chg_ovf"},  int'(chg_ovf),  m_ovf);
  endtask

  // One clock of stimulus; model follows the requirements; outputs sampled 1 ns after the edge
  task automatic step(input logic [1:0] la, lb, lc, input int ia, ib, ic, input logic stb);
    int cnt, s, v;
    @(negedge clk);
    lvl_a = la; lvl_b = lb; lvl_c = lc;
    cur_a = CUR_W'(ia); cur_b = CUR_W'(ib); cur_c = CUR_W'(ic);
    period_stb = stb;
    cnt = 0; s = 0;
    if (la == O) begin cnt++; s -= ia; end
    if (lb == O) begin cnt++; s -= ib; end
    if (lc == O) begin cnt++; s -= ic; end
    @(posedge clk);
    m_idle = (cnt == 0 || cnt == 3) ? 1 : 0;
    m_np   = m_idle ? 0 : s;
    v = m_acc + m_np;
    if (v > A_MAX) begin v = A_MAX; m_ovf = 1; end
    if (v < A_MIN) begin v = A_MIN; m_ovf = 1; end
    if (stb) begin m_snap = v; m_acc = 0; m_vld = 1; end
    else begin m_acc = v; m_vld = 0; end
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    lvl_a = N; lvl_b = N; lvl_c = N;
    cur_a = '0; cur_b = '0; cur_c = '0; period_stb = 1'b0;
    m_np = 0; m_idle = 0; m_acc = 0; m_snap = 0; m_vld = 0; m_ovf = 0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_all("R1 after release");
  endtask

  task automatic t_classify();
    step(P, P, N, 700, -300, -400, 1'b0); check_all("R2 large PPN");
    step(O, O, O, 100, 200, -50, 1'b0);   check_all("R2 zero OOO");
    step(N, N, N, 5, 6, 7, 1'b0);         check_all("R2 zero NNN");
    step(X, X, P, 900, -10, 3, 1'b0);     check_all("R2 code 11 non-middle");
    step(X, O, N, 40, -25, -15, 1'b0);    check_all("R2 code 11 with one middle");
  endtask

  task automatic t_select();
    step(P, O, N, 300, -120, -180, 1'b0);   check_all("R3 PON");
    step(O, O, N, -500, 200, 300, 1'b0);    check_all("R3 OON");
    step(O, P, O, 2047, -1000, -1047, 1'b0); check_all("R3 OPO");
    step(N, O, P, -2048, 1024, 1024, 1'b0); check_all("R3 NOP");
  endtask

  task automatic t_period();
    step(P, P, P, 0, 0, 0, 1'b1);           check_all("R4 strobe align");
    step(O, P, N, 100, -40, -60, 1'b0);     check_all("R4 sum 1");
    step(P, N, N, 800, -400, -400, 1'b0);   check_all("R9 idle adds none");
    step(O, O, P, 30, 20, -50, 1'b0);       check_all("R4 sum 2");
    step(P, O, N, 10, 70, -80, 1'b1);       check_all("R4 snapshot incl strobe sample");
    step(N, O, O, -11, 5, 6, 1'b0);         check_all("R6 held, vld drop");
    step(P, P, N, 1, 1, -2, 1'b0);          check_all("R6 held again");
    step(O, N, P, 250, -125, -125, 1'b1);   check_all("R5 restart from zero");
    step(O, O, O, 9, 9, 9, 1'b1);           check_all("R9 idle-only period");
  endtask

  task automatic t_sat(input int cv, input string tag);
    for (int k = 0; k < 135; k++) begin
      step(O, O, N, cv, cv, 0, 1'b0);
      check_all(tag);
    end
    step(P, P, P, 0, 0, 0, 1'b1); check_all({tag, " snapshot at limit"});
    step(P, O, N, 1, 2, -3, 1'b0); check_all({tag, " flag sticky R8"});
  endtask

  initial begin
    #900000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_classify();
    t_select();
    t_period();
    t_sat(-2048, "R7 positive saturation");
    do_reset();
    check("R8 cleared by reset", int'(chg_ovf), 0);
    t_sat(2047, "R7 negative saturation");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule